// File: doc/BRIEF.md
# Prescaled LED PWM controller

This block drives one active-high LED pin from a small register window. In its PWM mode each period lasts 256 × (LD+1) ticks of a chosen tick source. LD is a 12-bit prescale value. An 8-bit duty value sets how many of the 256 period slots the pin is driven high. The tick source is one of two single-cycle tick-enable inputs: a fast one and a slow one. Everything runs in the single `clk` domain, so no clock is switched.

Software writes the duty value and it takes effect at once. The prescale value goes through a holding register. It is copied into the active prescaler only after software sets an update-request bit, and then only at the next period boundary. Software can poll that bit, which clears itself when the copy is made. A soft-reset bit restarts the period counters without changing any register. The mode field selects one of three modes: forced low (counters idle), PWM, or forced high.

Top module: `led_pwm_ctrl`

## Requirements
- R1: After reset every register reads zero, the slow tick is selected, the mode is off and `led_o` is low.
- R2: Mode values 0 and 1 (config[1:0]) drive `led_o` low and hold the slot and prescale counters at zero.
- R3: Mode value 3 drives `led_o` high whatever the duty value.
- R4: In mode 2 a period spans 256 × (LD+1) selected ticks. Counting from the period start, the pin is high for the first duty × (LD+1) ticks, for duty 1 to 254.
- R5: In mode 2 a duty of 0 (limits[7:0]) keeps the pin low and a duty of 255 keeps it high for the whole period.
- R6: A write to limits (offset 1) changes the pin level on the next cycle, with no wait for a period boundary.
- R7: A write to the delay register (offset 2, LD in bits [11:0]) changes only the held value, and the active period length stays as it was.
- R8: Writing config[6]=1 sets a pending flag that reads back in config[6]. In mode 2 the held LD is copied, and the flag cleared, on the tick that ends the current period. In any other mode this happens on the next clock.
- R9: Writing config[7]=1 clears the slot and prescale counters on that write edge. The period then restarts from slot 0. Config[7] always reads 0.
- R10: Config[2]=1 makes the counters advance on `tick_fast_i`, and 0 makes them advance on `tick_slow_i`. The tick that is not selected has no effect.
- R11: The register offsets are: 0 config, 1 limits (16 bits stored), 2 delay (24 bits stored), 3 and 4 read zero, 5 output-delay count (8 bits stored). Unlisted bits and offsets 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast_i | input | 1 | Fast tick enable, one cycle wide |
| tick_slow_i | input | 1 | Slow tick enable, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| led_o | output | 1 | LED drive, active high |

## Verification
The checker assumes that reset is asserted at the start and that a write strobe carries a stable address and data for one whole clock. It also assumes that the tick inputs are plain enables sampled on the clock edge. The bench drives every input at the falling edge and holds a write for exactly one rising edge. It ties the unselected tick to a constant, or pulses it one cycle at a time. That way period lengths and update timing can be counted in whole clocks.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RSVD = 2'd1,
        MODE_PWM  = 2'd2,
        MODE_ON   = 2'd3
    } led_mode_e;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_LIM  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_DLY  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_STEP = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_IVL  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_ODLY = 3'd5;

    localparam int BIT_FAST = 2;
    localparam int BIT_UPD  = 6;
    localparam int BIT_SRST = 7;
endpackage

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
    import led_pwm_pkg::*;
#(
    parameter int PRE_W  = 12,
    parameter int DUTY_W = 8,
    parameter int ODLY_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 xfer,
    output logic [DATA_W-1:0]    rdata,
    output led_mode_e            mode,
    output logic                 fast_sel,
    output logic [DUTY_W-1:0]    duty,
    output logic [PRE_W-1:0]     ld_hold,
    output logic                 upd_pend,
    output logic                 srst
);
    localparam int LIM_W = 2 * DUTY_W;
    localparam int DLY_W = 2 * PRE_W;

    typedef struct packed {
        led_mode_e          mode;
        logic               fast;
        logic               upd;
        logic [LIM_W-1:0]   lim;
        logic [DLY_W-1:0]   dly;
        logic [ODLY_W-1:0]  odly;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    cfg_wr;

    always_comb begin
        st_d   = st_q;
        cfg_wr = wr_en && (addr == OFS_CFG);
        if (cfg_wr) begin
            st_d.mode = led_mode_e'(wdata[1:0]);
            st_d.fast = wdata[BIT_FAST];
        end
        st_d.upd = (st_q.upd & ~xfer) | (cfg_wr & wdata[BIT_UPD]);
        if (wr_en && addr == OFS_LIM)  st_d.lim  = wdata[LIM_W-1:0];
        if (wr_en && addr == OFS_DLY)  st_d.dly  = wdata[DLY_W-1:0];
        if (wr_en && addr == OFS_ODLY) st_d.odly = wdata[ODLY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CFG: begin
                rdata[1:0]      = st_q.mode;
                rdata[BIT_FAST] = st_q.fast;
                rdata[BIT_UPD]  = st_q.upd;
            end
            OFS_LIM:  rdata[LIM_W-1:0]  = st_q.lim;
            OFS_DLY:  rdata[DLY_W-1:0]  = st_q.dly;
            OFS_ODLY: rdata[ODLY_W-1:0] = st_q.odly;
            default:  rdata = '0;
        endcase
    end

    assign mode     = st_q.mode;
    assign fast_sel = st_q.fast;
    assign duty     = st_q.lim[DUTY_W-1:0];
    assign ld_hold  = st_q.dly[PRE_W-1:0];
    assign upd_pend = st_q.upd;
    assign srst     = cfg_wr & wdata[BIT_SRST];
endmodule

// File: rtl/led_pwm_core.sv
module led_pwm_core
    import led_pwm_pkg::*;
#(
    parameter int PRE_W  = 12,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              fast_sel,
    input  led_mode_e         mode,
    input  logic [DUTY_W-1:0] duty,
    input  logic [PRE_W-1:0]  ld_hold,
    input  logic              upd_pend,
    input  logic              srst,
    output logic              xfer,
    output logic              led,
    output logic [PRE_W-1:0]  pre_o,
    output logic [DUTY_W-1:0] cnt_o,
    output logic [PRE_W-1:0]  ld_o
);
    localparam logic [DUTY_W-1:0] SLOT_LAST = '1;
    localparam logic [DUTY_W-1:0] DUTY_ZERO = '0;
    localparam logic [DUTY_W-1:0] DUTY_FULL = '1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DUTY_W-1:0] cnt;
        logic [PRE_W-1:0]  ld;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     tick;

    assign tick = fast_sel ? tick_fast : tick_slow;

    always_comb begin
        st_d = st_q;
        xfer = 1'b0;
        if (srst) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else if (mode != MODE_PWM) begin
            st_d.pre = '0;
            st_d.cnt = '0;
            if (upd_pend) begin
                st_d.ld = ld_hold;
                xfer    = 1'b1;
            end
        end else if (tick) begin
            if (st_q.pre == st_q.ld) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == SLOT_LAST && upd_pend) begin
                    st_d.ld = ld_hold;
                    xfer    = 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (mode)
            MODE_ON:  led = 1'b1;
            MODE_PWM: begin
                if (duty == DUTY_ZERO)      led = 1'b0;
                else if (duty == DUTY_FULL) led = 1'b1;
                else                        led = (st_q.cnt < duty);
            end
            default:  led = 1'b0;
        endcase
    end

    assign pre_o = st_q.pre;
    assign cnt_o = st_q.cnt;
    assign ld_o  = st_q.ld;
endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
    import led_pwm_pkg::*;
#(
    parameter int PRE_W  = 12,
    parameter int DUTY_W = 8,
    parameter int ODLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast_i,
    input  logic              tick_slow_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              led_o
);
    led_mode_e         mode_w;
    logic              fast_w;
    logic [DUTY_W-1:0] duty_w;
    logic [PRE_W-1:0]  hold_w;
    logic              upd_w;
    logic              srst_w;
    logic              xfer_w;
    logic [PRE_W-1:0]  pre_w;
    logic [DUTY_W-1:0] cnt_w;
    logic [PRE_W-1:0]  ld_w;

    led_pwm_regs #(.PRE_W(PRE_W), .DUTY_W(DUTY_W), .ODLY_W(ODLY_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .xfer(xfer_w), .rdata(rdata_o), .mode(mode_w),
        .fast_sel(fast_w), .duty(duty_w), .ld_hold(hold_w),
        .upd_pend(upd_w), .srst(srst_w)
    );

    led_pwm_core #(.PRE_W(PRE_W), .DUTY_W(DUTY_W)) core_i (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast_i),
        .tick_slow(tick_slow_i), .fast_sel(fast_w), .mode(mode_w),
        .duty(duty_w), .ld_hold(hold_w), .upd_pend(upd_w), .srst(srst_w),
        .xfer(xfer_w), .led(led_o), .pre_o(pre_w), .cnt_o(cnt_w), .ld_o(ld_w)
    );
endmodule

// File: rtl/led_pwm_chk.sv
module led_pwm_chk #(
    parameter int PRE_W  = 12,
    parameter int DUTY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              led,
    input logic [1:0]        mode,
    input logic [DUTY_W-1:0] duty,
    input logic              upd_pend,
    input logic              xfer,
    input logic              srst,
    input logic [PRE_W-1:0]  pre,
    input logic [DUTY_W-1:0] cnt,
    input logic [PRE_W-1:0]  ld_act
);
    localparam logic [DUTY_W-1:0] D_ZERO = '0;
    localparam logic [DUTY_W-1:0] D_FULL = '1;

    a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0) |-> !led);
    a_r2_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0) |=> (cnt == '0 && pre == '0));
    a_r3_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> led);
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && duty == D_ZERO) |-> !led);
    a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && duty == D_FULL) |-> led);
    a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre <= ld_act);
    a_r7_ld_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(ld_act));
    a_r8_xfer_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> upd_pend);
    a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (cnt == '0 && pre == '0));
endmodule

bind led_pwm_ctrl led_pwm_chk #(.PRE_W(PRE_W), .DUTY_W(DUTY_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .led(led_o), .mode(mode_w), .duty(duty_w),
    .upd_pend(upd_w), .xfer(xfer_w), .srst(srst_w), .pre(pre_w),
    .cnt(cnt_w), .ld_act(ld_w)
);

// File: tb/led_pwm_ctrl_tb_top.sv
module led_pwm_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_fast = 1'b1;
    logic        tick_slow = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        led;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    led_pwm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_fast_i(tick_fast),
        .tick_slow_i(tick_slow), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .led_o(led)
    );

    // {ld[11:0], duty[7:0], expected high ticks[19:0]}
    localparam logic [39:0] VEC [7] = '{
        {12'd0, 8'd1,   20'd1},
        {12'd0, 8'd128, 20'd128},
        {12'd1, 8'd100, 20'd200},
        {12'd3, 8'd254, 20'd1016},
        {12'd2, 8'd0,   20'd0},
        {12'd0, 8'd255, 20'd256},
        {12'd4, 8'd37,  20'd185}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            if (led) h++;
            @(negedge clk);
        end
    endtask

    // load LD through an update taken while off, then start PWM on the fast tick
    task automatic start_pwm(input logic [11:0] ld, input logic [7:0] duty);
        wr(3'd2, {20'd0, ld});
        wr(3'd1, {24'd0, duty});
        wr(3'd0, 32'h44);
        wr(3'd0, 32'h86);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 config", v, 32'h0);
        rd(3'd1, v); check("R1 limits", v, 32'h0);
        rd(3'd2, v); check("R1 delay", v, 32'h0);
        check("R1 led", {31'd0, led}, 32'd0);

        // R4 R5 table of period/duty cases
        for (int i = 0; i < 7; i++) begin
            start_pwm(VEC[i][39:28], VEC[i][27:20]);
            count_high(256 * (int'(VEC[i][39:28]) + 1), h);
            check($sformatf("R4 R5 vector %0d high ticks", i), h, {12'd0, VEC[i][19:0]});
        end

        // R7 delay write is held only
        start_pwm(12'd0, 8'd128);
        wr(3'd2, 32'd3);
        rd(3'd2, v); check("R7 held readback", v, 32'd3);
        wr(3'd0, 32'h86);
        count_high(256, h);
        check("R7 period unchanged", h, 32'd128);

        // R8 update at period boundary, self-clear
        wr(3'd0, 32'hC6);
        for (int k = 0; k < 255; k++) @(negedge clk);
        rd(3'd0, v); check("R8 pending before boundary", {31'd0, v[6]}, 32'd1);
        @(negedge clk);
        rd(3'd0, v); check("R8 cleared at boundary", {31'd0, v[6]}, 32'd0);
        count_high(1024, h);
        check("R8 new period high ticks", h, 32'd512);

        // R6 limits immediate; R9 soft reset restart
        wr(3'd1, 32'd0);
        wr(3'd0, 32'h86);
        check("R6 duty0 low", {31'd0, led}, 32'd0);
        wr(3'd1, 32'd200);
        check("R6 duty200 high at once", {31'd0, led}, 32'd1);

        // R3 and R2
        wr(3'd0, 32'h3);
        check("R3 on high", {31'd0, led}, 32'd1);
        wr(3'd0, 32'h0);
        check("R2 off low", {31'd0, led}, 32'd0);
        wr(3'd0, 32'h1);
        check("R2 reserved low", {31'd0, led}, 32'd0);

        // R10 slow tick selected, fast tick ignored
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h40);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'h82);
        repeat (300) @(negedge clk);
        check("R10 fast tick ignored", {31'd0, led}, 32'd1);
        tick_slow = 1'b1;
        @(negedge clk);
        tick_slow = 1'b0;
        check("R10 slow tick advances", {31'd0, led}, 32'd0);

        // R11 map and widths; R9 srst bit reads zero
        wr(3'd2, 32'hFFABCDEF);
        rd(3'd2, v); check("R11 delay 24 bits", v, 32'h00ABCDEF);
        wr(3'd5, 32'hFFFF);
        rd(3'd5, v); check("R11 output delay 8 bits", v, 32'hFF);
        wr(3'd1, 32'hFFFFFFFF);
        rd(3'd1, v); check("R11 limits 16 bits", v, 32'hFFFF);
        wr(3'd3, 32'hFFFFFFFF);
        rd(3'd3, v); check("R11 offset 3 zero", v, 32'h0);
        rd(3'd7, v); check("R11 offset 7 zero", v, 32'h0);
        wr(3'd0, 32'hFF);
        rd(3'd0, v); check("R9 R11 config readback", v, 32'h47);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule